// File: doc/BRIEF.md
# Byte-Lane Select Generator

This block drives the eight active-low byte-lane strobes of a 64-bit external data bus that sits behind a memory controller. In every cycle it reads the port width of the bank being accessed, the transfer size and the three low address bits, and works out which byte lanes carry valid data. Lanes are numbered from the most significant byte: strobe 0 covers data bits 0 to 7, which is the top byte in big-endian numbering. Strobe 1 covers bits 8 to 15, and the pattern continues up to strobe 7.

The decode only says *which* lanes respond. *When* they change is set by the external timing machine. That machine issues a one-cycle assert command or a one-cycle negate command, following its per-cycle timing word. On an assert command the strobes take the decoded pattern. On a negate command they all return high. When a refresh request is present with an assert command, the decode is ignored and all eight lanes are driven together.

The block is built around a three-state machine:

- **IDLE**: all strobes are negated.
- **DATA**: the strobes hold the decoded lane pattern.
- **RFSH**: all strobes are asserted for a refresh.

Its transitions are:

- **GO_DATA**: an assert command without refresh, taken from any state.
- **GO_RFSH**: an assert command with refresh, taken from any state.
- **GO_IDLE**: a negate command, taken from any state.
- **STAY**: no command, so the state holds.

Top module: `bls_gen`

## Requirements
- R1: After reset, `bs_n` is 8'hFF (all lanes negated) and `misalign` is 0.
- R2: `bs_n[i]` low means byte lane i, data bits 8i to 8i+7, is valid, with lane 0 the most significant byte. On a 64-bit port (`port_sz`=00) an assert enables lanes `addr_lo` through `addr_lo`+size-1.
- R3: The `port_sz` encoding is 00 = 64-bit, 01 = 8-bit, 10 = 16-bit and 11 = 32-bit. A narrow port uses only the uppermost lanes: lane 0 only for 8-bit, lanes 0-1 for 16-bit, and lanes 0-3 for 32-bit. The lane offset is `addr_lo` modulo the port width in bytes.
- R4: The `xfer_sz` encoding is 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes and 11 = 8 bytes.
- R5: When offset plus size exceeds the port width, only the lanes from the offset up to the port boundary are enabled, with no wrap to lane 0, and `misalign` is set to 1 by that assert.
- R6: Outputs change only in the cycle after an assert or negate command. With no command, `bs_n` and `misalign` hold even when the decode inputs change.
- R7: A negate command drives `bs_n` to 8'hFF and clears `misalign` in the following cycle. It takes priority over an assert command in the same cycle.
- R8: An assert command with `refresh_req` high drives `bs_n` to 8'h00 whatever the decode inputs are, and clears `misalign`.
- R9: An assert command without refresh always enables at least one lane. A set `misalign` is only ever seen together with at least one enabled lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_sz | input | 2 | Port width code of the accessed bank |
| xfer_sz | input | 2 | Transfer size code |
| addr_lo | input | 3 | Low-order address bits |
| cmd_assert | input | 1 | Timing-machine assert command, one cycle |
| cmd_negate | input | 1 | Timing-machine negate command, one cycle |
| refresh_req | input | 1 | Current cycle is a refresh-timer request |
| bs_n | output | 8 | Active-low byte-lane strobes; bit i is lane i |
| misalign | output | 1 | Last assert crossed the port boundary |

## Verification
The assertions are checked on every cycle and cover the following:

- Strobes hold between commands.
- A negate returns all lanes high.
- A refresh assert drives all lanes low.
- Narrow ports never touch the lanes above their width.
- Each state agrees with the strobe pattern.
- A data assert never leaves every lane negated.

Some behaviours can only be shown by the bench's scenarios, which compare the outputs against an independent model over random and directed combinations:

- The exact lane pattern for each port width, size and offset.
- The modulo offset.
- Clipping at the port boundary.
- The value of the misalignment flag.

// File: rtl/bls_pkg.sv
package bls_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_RFSH = 2'd2
    } bls_state_e;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_NEG  = 2'd1,
        CMD_DATA = 2'd2,
        CMD_RFSH = 2'd3
    } bls_cmd_e;

    typedef enum logic [1:0] {
        PS_64 = 2'b00,
        PS_8  = 2'b01,
        PS_16 = 2'b10,
        PS_32 = 2'b11
    } port_size_e;

endpackage

// File: rtl/bls_cmd.sv
// Reduces the timing-machine controls to one command; negate wins (R7).
module bls_cmd
    import bls_pkg::*;
(
    input  logic     cmd_assert,
    input  logic     cmd_negate,
    input  logic     refresh_req,
    output bls_cmd_e cmd
);

    always_comb begin
        if (cmd_negate) begin
            cmd = CMD_NEG;
        end else if (cmd_assert && refresh_req) begin
            cmd = CMD_RFSH;
        end else if (cmd_assert) begin
            cmd = CMD_DATA;
        end else begin
            cmd = CMD_NONE;
        end
    end

endmodule

// File: rtl/bls_decode.sv
// Lane decode from port width, transfer size and low address bits.
module bls_decode
    import bls_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic [1:0]               port_sz,
    input  logic [1:0]               xfer_sz,
    input  logic [$clog2(LANES)-1:0] addr_lo,
    output logic [LANES-1:0]         lane_en,
    output logic                     mis
);

    localparam int OFF_W = $clog2(LANES);
    localparam int CNT_W = OFF_W + 2;

    logic [CNT_W-1:0] width_b;
    logic [CNT_W-1:0] offset_b;
    logic [CNT_W-1:0] size_b;
    logic [CNT_W-1:0] end_b;

    // Port width in bytes (R3).
    always_comb begin
        unique case (port_size_e'(port_sz))
            PS_64:   width_b = CNT_W'(LANES);
            PS_8:    width_b = CNT_W'(1);
            PS_16:   width_b = CNT_W'(2);
            PS_32:   width_b = CNT_W'(4);
            default: width_b = CNT_W'(LANES);
        endcase
    end

    always_comb begin
        // The offset wraps modulo the port width (R3).
        offset_b = CNT_W'(addr_lo) & (width_b - CNT_W'(1));
        // The transfer size is a power of two in bytes (R4).
        size_b   = CNT_W'(1) << xfer_sz;
        end_b    = offset_b + size_b;
        // Crossing the port boundary raises the flag (R5).
        mis      = end_b > width_b;
    end

    // One comparator set per lane; bit i is lane i, counted from the MSB byte (R2).
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_en[i] = (CNT_W'(i) >= offset_b) &&
                            (CNT_W'(i) <  end_b)    &&
                            (CNT_W'(i) <  width_b);
    end

endmodule

// File: rtl/bls_fsm.sv
// State register and registered strobe outputs.
module bls_fsm
    import bls_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bls_cmd_e         cmd,
    input  logic [LANES-1:0] lane_en,
    input  logic             mis,
    output bls_state_e       st,
    output logic [LANES-1:0] bs_n,
    output logic             misalign
);

    localparam logic [LANES-1:0] ALL_NEG = '1;
    localparam logic [LANES-1:0] ALL_ACT = '0;

    bls_state_e st_nxt;

    always_comb begin
        unique case (cmd)
            CMD_NEG:  st_nxt = ST_IDLE;   // GO_IDLE
            CMD_DATA: st_nxt = ST_DATA;   // GO_DATA
            CMD_RFSH: st_nxt = ST_RFSH;   // GO_RFSH
            CMD_NONE: st_nxt = st;        // STAY
            default:  st_nxt = st;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // Output register: it changes only on a command (R6).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bs_n     <= ALL_NEG;
            misalign <= 1'b0;
        end else begin
            unique case (cmd)
                CMD_NEG: begin
                    bs_n     <= ALL_NEG;
                    misalign <= 1'b0;
                end
                CMD_RFSH: begin
                    bs_n     <= ALL_ACT;
                    misalign <= 1'b0;
                end
                CMD_DATA: begin
                    bs_n     <= ~lane_en;
                    misalign <= mis;
                end
                CMD_NONE: begin
                    bs_n     <= bs_n;
                    misalign <= misalign;
                end
                default: begin
                    bs_n     <= bs_n;
                    misalign <= misalign;
                end
            endcase
        end
    end

endmodule

// File: rtl/bls_gen.sv
module bls_gen
    import bls_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               port_sz,
    input  logic [1:0]               xfer_sz,
    input  logic [$clog2(LANES)-1:0] addr_lo,
    input  logic                     cmd_assert,
    input  logic                     cmd_negate,
    input  logic                     refresh_req,
    output logic [LANES-1:0]         bs_n,
    output logic                     misalign
);

    bls_cmd_e         cmd;
    logic [LANES-1:0] lane_en;
    logic             mis;
    bls_state_e       st;

    bls_cmd u_cmd (
        .cmd_assert  (cmd_assert),
        .cmd_negate  (cmd_negate),
        .refresh_req (refresh_req),
        .cmd         (cmd)
    );

    bls_decode #(.LANES(LANES)) u_dec (
        .port_sz (port_sz),
        .xfer_sz (xfer_sz),
        .addr_lo (addr_lo),
        .lane_en (lane_en),
        .mis     (mis)
    );

    bls_fsm #(.LANES(LANES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .lane_en  (lane_en),
        .mis      (mis),
        .st       (st),
        .bs_n     (bs_n),
        .misalign (misalign)
    );

endmodule

// File: rtl/bls_gen_chk.sv
module bls_gen_chk
    import bls_pkg::*;
#(
    parameter int LANES = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       port_sz,
    input logic             cmd_assert,
    input logic             cmd_negate,
    input logic             refresh_req,
    input logic [LANES-1:0] bs_n,
    input logic             misalign,
    input bls_state_e       st
);

    localparam logic [LANES-1:0] ALL_NEG = '1;

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_assert && !cmd_negate) |=> ($stable(bs_n) && $stable(misalign)));

    p_negate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_negate |=> (bs_n == ALL_NEG && !misalign));

    p_refresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_assert && refresh_req && !cmd_negate) |=> (bs_n == '0 && !misalign));

    p_port8_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_assert && !refresh_req && !cmd_negate && port_sz == 2'b01)
            |=> (bs_n[LANES-1:1] == '1));

    p_port16_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_assert && !refresh_req && !cmd_negate && port_sz == 2'b10)
            |=> (bs_n[LANES-1:2] == '1));

    p_port32_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_assert && !refresh_req && !cmd_negate && port_sz == 2'b11)
            |=> (bs_n[LANES-1:4] == '1));

    p_some_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_assert && !refresh_req && !cmd_negate) |=> (bs_n != ALL_NEG));

    p_mis_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (bs_n != ALL_NEG));

    p_idle_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (bs_n == ALL_NEG && !misalign));

    p_rfsh_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RFSH) |-> (bs_n == '0));

endmodule

bind bls_gen bls_gen_chk #(.LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .port_sz     (port_sz),
    .cmd_assert  (cmd_assert),
    .cmd_negate  (cmd_negate),
    .refresh_req (refresh_req),
    .bs_n        (bs_n),
    .misalign    (misalign),
    .st          (st)
);

// File: tb/sim_bls_gen.sv
`timescale 1ns/1ps
module sim_bls_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] port_sz = 2'b00;
    logic [1:0] xfer_sz = 2'b00;
    logic [2:0] addr_lo = 3'd0;
    logic       cmd_assert = 1'b0;
    logic       cmd_negate = 1'b0;
    logic       refresh_req = 1'b0;
    logic [7:0] bs_n;
    logic       misalign;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_bs = 8'hFF;
    logic       exp_mis = 1'b0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    bls_gen u0 (
        .clk(clk), .rst_n(rst_n), .port_sz(port_sz), .xfer_sz(xfer_sz),
        .addr_lo(addr_lo), .cmd_assert(cmd_assert), .cmd_negate(cmd_negate),
        .refresh_req(refresh_req), .bs_n(bs_n), .misalign(misalign)
    );

    // Model: bit 8 is the misalign flag, bits 7:0 are the enabled lanes.
    function automatic logic [8:0] model(input logic [1:0] ps, input logic [1:0] xs,
                                         input logic [2:0] a);
        int w;
        int off;
        int sz;
        logic [7:0] en;
        case (ps)
            2'b01:   w = 1;
            2'b10:   w = 2;
            2'b11:   w = 4;
            default: w = 8;
        endcase
        off = int'(a) % w;
        sz  = 1 << xs;
        en  = '0;
        for (int i = 0; i < 8; i++) begin
            if (i >= off && i < off + sz && i < w) en[i] = 1'b1;
        end
        return {(off + sz > w), en};
    endfunction

    task automatic check(input string req);
        checks++;
        if (bs_n !== exp_bs || misalign !== exp_mis) begin
            errors++;
            $display("FAIL %s bs_n=%h mis=%b expected bs_n=%h mis=%b",
                     req, bs_n, misalign, exp_bs, exp_mis);
        end
    endtask

    // Drive one cycle at the falling edge, update the model, then sample at the next falling edge.
    task automatic step(input logic as, input logic ng, input logic rf,
                        input logic [1:0] ps, input logic [1:0] xs, input logic [2:0] a,
                        input string req);
        logic [8:0] m;
        cmd_assert = as; cmd_negate = ng; refresh_req = rf;
        port_sz = ps; xfer_sz = xs; addr_lo = a;
        if (ng) begin
            exp_bs = 8'hFF; exp_mis = 1'b0;
        end else if (as && rf) begin
            exp_bs = 8'h00; exp_mis = 1'b0;
        end else if (as) begin
            m = model(ps, xs, a);
            exp_bs = ~m[7:0]; exp_mis = m[8];
        end
        @(negedge clk);
        cmd_assert = 1'b0; cmd_negate = 1'b0; refresh_req = 1'b0;
        check(req);
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release");

        // Directed corner cases.
        step(1, 0, 0, 2'b00, 2'b01, 3'd3, "R2 64-bit two bytes at 3");         // E7
        step(1, 0, 0, 2'b00, 2'b11, 3'd0, "R4 64-bit eight bytes");            // 00
        step(0, 1, 0, 2'b00, 2'b00, 3'd0, "R7 negate");
        step(1, 0, 0, 2'b10, 2'b00, 3'd3, "R3 16-bit offset modulo");          // FD
        step(1, 0, 0, 2'b01, 2'b10, 3'd5, "R5 8-bit clipped");                 // FE mis
        step(1, 0, 0, 2'b11, 2'b10, 3'd6, "R5 32-bit clipped");                // F3 mis
        step(0, 0, 0, 2'b00, 2'b11, 3'd0, "R6 hold with new inputs");
        step(0, 0, 1, 2'b01, 2'b00, 3'd1, "R6 refresh alone ignored");
        step(1, 1, 0, 2'b00, 2'b11, 3'd0, "R7 negate beats assert");
        step(1, 0, 1, 2'b01, 2'b00, 3'd0, "R8 refresh drives all");
        step(1, 0, 0, 2'b00, 2'b10, 3'd6, "R5 64-bit clipped");                // lanes 6,7 mis
        step(1, 0, 1, 2'b00, 2'b10, 3'd6, "R8 refresh clears misalign");
        step(1, 0, 0, 2'b11, 2'b00, 3'd7, "R9 32-bit single byte");            // lane 3

        // Random mix.
        for (int n = 0; n < 400; n++) begin
            logic [3:0] r;
            r = 4'($urandom_range(0, 15));
            step(r < 4'd9, r == 4'd12 || r == 4'd13, r[0] && r > 4'd7,
                 2'($urandom), 2'($urandom), 3'($urandom), "R2 R3 R4 R5 R6 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule